// File: doc/BRIEF.md
# Dual-Port RAM Port Controller

This block is a word-addressed memory with two fully independent access ports, a left one and a right one, each with its own address, controls and 18-bit data lanes. Every word is split into two 9-bit lanes: the lower lane holds bits 8:0 and the upper lane holds bits 17:9. On each clock, each port's controls are decoded into one of these modes: deselected, sleeping, no lane picked, write, read, or read with outputs held off. The chosen mode decides which lanes are stored and which lanes are driven.

A port is reached only through a pair of enables of opposite polarity. A per-port sleep input overrides every other control on that port. Read data is registered: it appears, with a per-lane drive flag for an external tri-state pad, one clock after the edge that samples the address. The surrounding logic builds the pads from `rdata` and `drive`. Both ports may address the same word in the same cycle. When both write the same lane of the same word in one cycle, the left port wins. A port that reads a word in the same cycle as the other port writes it gets the old contents.

Top module: `dpr_port_ctrl`

## Requirements
- R1: A port is selected only while its `ce0_n` is 0 and its `ce1` is 1. With any other pair it stores nothing, and after the next clock edge both bits of its `drive` are 0.
- R2: Lane select bit 0 (`lane_n[0]`) governs data bits 8:0 and bit 1 (`lane_n[1]`) governs bits 17:9. Both are active low. A write stores only the lanes whose select is 0 and leaves the other lane of the word unchanged.
- R3: With the port selected and `rw` = 0, the selected lanes of `wdata` are stored at `addr` on the clock edge, whatever the value of `oe_n`. After that edge `drive` is 0.
- R4: With the port selected, `rw` = 1 and `oe_n` = 0, after the clock edge `rdata` holds the full word stored at `addr` before that edge. `drive` then has a 1 for each lane whose select was 0.
- R5: With the port selected, `rw` = 1 and `oe_n` = 1, nothing is stored, `rdata` is unchanged and `drive` is 0 after the edge.
- R6: With both lane selects at 1, a selected port stores nothing, leaves `rdata` unchanged and has `drive` at 0 after the edge.
- R7: While `sleep` is 1, the port's `drive` is 0 in that same cycle and the port stores nothing, whatever its other controls are.
- R8: Both ports may read the same word in the same cycle, and each receives it.
- R9: When one port writes a word in the cycle the other port reads it, the reader receives the contents from before the write. A later read returns the new data.
- R10: When both ports write the same lane of the same word in one cycle, the left port's data is stored. Different lanes written by the two ports are both stored.
- R11: During and after reset, `rdata` is 0 and `drive` is 0 on both ports until the first read.
- R12: `rdata` keeps the last word read until the port reads again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read registers |
| pa_ce0_n | input | 1 | Left port enable, active low |
| pa_ce1 | input | 1 | Left port enable, active high |
| pa_rw | input | 1 | Left port direction, 1 read, 0 write |
| pa_oe_n | input | 1 | Left port output enable, active low |
| pa_lane_n | input | 2 | Left port lane selects, active low; bit 0 lower, bit 1 upper |
| pa_sleep | input | 1 | Left port sleep, overrides all left controls |
| pa_addr | input | ADDR_W | Left port word address |
| pa_wdata | input | 2*LANE_W | Left port write data |
| pa_rdata | output | 2*LANE_W | Left port registered read data |
| pa_drive | output | 2 | Left port per-lane drive enable for the data pads |
| pb_ce0_n | input | 1 | Right port enable, active low |
| pb_ce1 | input | 1 | Right port enable, active high |
| pb_rw | input | 1 | Right port direction, 1 read, 0 write |
| pb_oe_n | input | 1 | Right port output enable, active low |
| pb_lane_n | input | 2 | Right port lane selects, active low; bit 0 lower, bit 1 upper |
| pb_sleep | input | 1 | Right port sleep, overrides all right controls |
| pb_addr | input | ADDR_W | Right port word address |
| pb_wdata | input | 2*LANE_W | Right port write data |
| pb_rdata | output | 2*LANE_W | Right port registered read data |
| pb_drive | output | 2 | Right port per-lane drive enable for the data pads |

## Verification
The bench builds the block with ADDR_W = 4, so the memory has only sixteen words. Random traffic from the two ports therefore lands on the same word often, which exercises the left-wins write collision and the old-data rule for a read during a write with no directed setup. LANE_W stays at 9, so lane-split writes show up as distinct 9-bit halves in the 18-bit model word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int LANES = 2;

  typedef enum logic [2:0] {
    MD_DESEL,
    MD_SLEEP,
    MD_NOLANE,
    MD_WRITE,
    MD_READ,
    MD_OUTOFF
  } mode_e;

  typedef struct packed {
    mode_e            mode;
    logic [LANES-1:0] wr_lanes;
    logic [LANES-1:0] rd_lanes;
  } port_ctl_t;

  // Per-port decode: sleep first, then the enable pair, then direction.
  function automatic port_ctl_t decode_port(
    input logic             ce0_n,
    input logic             ce1,
    input logic             rw,
    input logic             oe_n,
    input logic [LANES-1:0] lane_n,
    input logic             sleep
  );
    port_ctl_t c;
    c.wr_lanes = '0;
    c.rd_lanes = '0;
    if (sleep)                     c.mode = MD_SLEEP;
    else if (ce0_n || !ce1)        c.mode = MD_DESEL;
    else if (&lane_n)              c.mode = MD_NOLANE;
    else if (!rw)                  c.mode = MD_WRITE;
    else if (oe_n)                 c.mode = MD_OUTOFF;
    else                           c.mode = MD_READ;
    if (c.mode == MD_WRITE) c.wr_lanes = ~lane_n;
    if (c.mode == MD_READ)  c.rd_lanes = ~lane_n;
    return c;
  endfunction

endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
  import dpr_pkg::*;
(
  input  logic             ce0_n,
  input  logic             ce1,
  input  logic             rw,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             sleep,
  output port_ctl_t        ctl
);
  assign ctl = decode_port(ce0_n, ce1, rw, oe_n, lane_n, sleep);
endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_a,
  input  logic [ADDR_W-1:0]       addr_a,
  input  logic [LANES*LANE_W-1:0] wdata_a,
  input  logic [LANES-1:0]        we_b,
  input  logic [ADDR_W-1:0]       addr_b,
  input  logic [LANES*LANE_W-1:0] wdata_b,
  output logic [LANES*LANE_W-1:0] raw_a,
  output logic [LANES*LANE_W-1:0] raw_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];

  // Right port first, left port last: left wins a same-lane collision.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_b[l]) mem[addr_b][l] <= wdata_b[l*LANE_W +: LANE_W];
      if (we_a[l]) mem[addr_a][l] <= wdata_a[l*LANE_W +: LANE_W];
    end
  end

  // Combinational look-up, sampled by the read stage on the same edge
  // as the write, so a colliding reader sees the pre-write word.
  assign raw_a = mem[addr_a];
  assign raw_b = mem[addr_b];
endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage
  import dpr_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        rd_lanes,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        drive
);
  logic [LANES*LANE_W-1:0] data_q;
  logic [LANES-1:0]        drive_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      drive_q <= '0;
    end else begin
      drive_q <= rd_lanes;
      if (|rd_lanes) data_q <= raw;
    end
  end

  assign rdata = data_q;
  assign drive = drive_q & {LANES{~sleep}};
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pa_ce0_n,
  input  logic                  pa_ce1,
  input  logic                  pa_rw,
  input  logic                  pa_oe_n,
  input  logic [1:0]            pa_lane_n,
  input  logic                  pa_sleep,
  input  logic [ADDR_W-1:0]     pa_addr,
  input  logic [2*LANE_W-1:0]   pa_wdata,
  output logic [2*LANE_W-1:0]   pa_rdata,
  output logic [1:0]            pa_drive,
  input  logic                  pb_ce0_n,
  input  logic                  pb_ce1,
  input  logic                  pb_rw,
  input  logic                  pb_oe_n,
  input  logic [1:0]            pb_lane_n,
  input  logic                  pb_sleep,
  input  logic [ADDR_W-1:0]     pb_addr,
  input  logic [2*LANE_W-1:0]   pb_wdata,
  output logic [2*LANE_W-1:0]   pb_rdata,
  output logic [1:0]            pb_drive
);
  localparam int NPORT  = 2;
  localparam int WORD_W = LANES * LANE_W;

  logic              c0n   [NPORT];
  logic              c1    [NPORT];
  logic              rwv   [NPORT];
  logic              oen   [NPORT];
  logic [LANES-1:0]  lnn   [NPORT];
  logic              slp   [NPORT];
  logic [WORD_W-1:0] raw   [NPORT];
  logic [WORD_W-1:0] rdat  [NPORT];
  logic [LANES-1:0]  drv   [NPORT];
  port_ctl_t         ctl   [NPORT];

  assign c0n[0] = pa_ce0_n;  assign c0n[1] = pb_ce0_n;
  assign c1[0]  = pa_ce1;    assign c1[1]  = pb_ce1;
  assign rwv[0] = pa_rw;     assign rwv[1] = pb_rw;
  assign oen[0] = pa_oe_n;   assign oen[1] = pb_oe_n;
  assign lnn[0] = pa_lane_n; assign lnn[1] = pb_lane_n;
  assign slp[0] = pa_sleep;  assign slp[1] = pb_sleep;

  // Named internal events for the checker.
  logic [LANES-1:0] wr_lanes_a, wr_lanes_b;
  logic [LANES-1:0] rd_lanes_a, rd_lanes_b;
  mode_e            mode_a, mode_b;
  logic             same_word;
  assign wr_lanes_a = ctl[0].wr_lanes;
  assign wr_lanes_b = ctl[1].wr_lanes;
  assign rd_lanes_a = ctl[0].rd_lanes;
  assign rd_lanes_b = ctl[1].rd_lanes;
  assign mode_a     = ctl[0].mode;
  assign mode_b     = ctl[1].mode;
  assign same_word  = (pa_addr == pb_addr);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_decode u_dec (
      .ce0_n  (c0n[p]),
      .ce1    (c1[p]),
      .rw     (rwv[p]),
      .oe_n   (oen[p]),
      .lane_n (lnn[p]),
      .sleep  (slp[p]),
      .ctl    (ctl[p])
    );

    dpr_read_stage #(.LANE_W(LANE_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_lanes (ctl[p].rd_lanes),
      .sleep    (slp[p]),
      .raw      (raw[p]),
      .rdata    (rdat[p]),
      .drive    (drv[p])
    );
  end

  dpr_mem_core #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .we_a    (wr_lanes_a),
    .addr_a  (pa_addr),
    .wdata_a (pa_wdata),
    .we_b    (wr_lanes_b),
    .addr_b  (pb_addr),
    .wdata_b (pb_wdata),
    .raw_a   (raw[0]),
    .raw_b   (raw[1])
  );

  assign pa_rdata = rdat[0];
  assign pb_rdata = rdat[1];
  assign pa_drive = drv[0];
  assign pb_drive = drv[1];
endmodule

// File: rtl/dpr_port_ctrl_chk.sv
module dpr_port_ctrl_chk
  import dpr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pa_ce0_n,
  input logic       pa_ce1,
  input logic       pa_rw,
  input logic       pa_oe_n,
  input logic [1:0] pa_lane_n,
  input logic       pa_sleep,
  input logic [1:0] pa_drive,
  input logic       pb_ce0_n,
  input logic       pb_ce1,
  input logic       pb_sleep,
  input logic [1:0] pb_drive,
  input logic [1:0] wr_lanes_a,
  input logic [1:0] wr_lanes_b,
  input mode_e      mode_a
);
  logic sel_a, sel_b;
  assign sel_a = !pa_ce0_n && pa_ce1 && !pa_sleep;
  assign sel_b = !pb_ce0_n && pb_ce1 && !pb_sleep;

  assert_desel_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_ce0_n || !pa_ce1) |-> (wr_lanes_a == 2'b00) ##1 (pa_drive == 2'b00));

  assert_desel_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_ce0_n || !pb_ce1) |-> (wr_lanes_b == 2'b00) ##1 (pb_drive == 2'b00));

  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && !pa_rw) |=> (pa_drive == 2'b00));

  assert_read_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && pa_rw && !pa_oe_n) |=> (pa_sleep || pa_drive == ~$past(pa_lane_n)));

  assert_outoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a && pa_rw && pa_oe_n) |-> (wr_lanes_a == 2'b00) ##1 (pa_drive == 2'b00));

  assert_nolane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_lane_n == 2'b11) |-> (wr_lanes_a == 2'b00) ##1 (pa_drive == 2'b00));

  assert_sleep_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pa_sleep |-> (pa_drive == 2'b00 && wr_lanes_a == 2'b00 && mode_a == MD_SLEEP));

  assert_sleep_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pb_sleep |-> (pb_drive == 2'b00 && wr_lanes_b == 2'b00));

  assert_drive_gate_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel_b) |-> (pb_drive == 2'b00));
endmodule

bind dpr_port_ctrl dpr_port_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pa_ce0_n   (pa_ce0_n),
  .pa_ce1     (pa_ce1),
  .pa_rw      (pa_rw),
  .pa_oe_n    (pa_oe_n),
  .pa_lane_n  (pa_lane_n),
  .pa_sleep   (pa_sleep),
  .pa_drive   (pa_drive),
  .pb_ce0_n   (pb_ce0_n),
  .pb_ce1     (pb_ce1),
  .pb_sleep   (pb_sleep),
  .pb_drive   (pb_drive),
  .wr_lanes_a (wr_lanes_a),
  .wr_lanes_b (wr_lanes_b),
  .mode_a     (mode_a)
);

// File: tb/dpr_port_ctrl_test.sv
module dpr_port_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int WW = 2 * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          ce0_n [2];
  logic          ce1   [2];
  logic          rw    [2];
  logic          oe_n  [2];
  logic [1:0]    lane_n[2];
  logic          sleep [2];
  logic [AW-1:0] addr  [2];
  logic [WW-1:0] wdata [2];
  logic [WW-1:0] rdata [2];
  logic [1:0]    drive [2];

  logic [WW-1:0] pa_rdata, pb_rdata;
  logic [1:0]    pa_drive, pb_drive;
  assign rdata[0] = pa_rdata; assign rdata[1] = pb_rdata;
  assign drive[0] = pa_drive; assign drive[1] = pb_drive;

  dpr_port_ctrl #(.ADDR_W(AW), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .pa_ce0_n(ce0_n[0]), .pa_ce1(ce1[0]), .pa_rw(rw[0]), .pa_oe_n(oe_n[0]),
    .pa_lane_n(lane_n[0]), .pa_sleep(sleep[0]), .pa_addr(addr[0]),
    .pa_wdata(wdata[0]), .pa_rdata(pa_rdata), .pa_drive(pa_drive),
    .pb_ce0_n(ce0_n[1]), .pb_ce1(ce1[1]), .pb_rw(rw[1]), .pb_oe_n(oe_n[1]),
    .pb_lane_n(lane_n[1]), .pb_sleep(sleep[1]), .pb_addr(addr[1]),
    .pb_wdata(wdata[1]), .pb_rdata(pb_rdata), .pb_drive(pb_drive)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [WW-1:0] model [DEPTH];
  logic [WW-1:0] exp_rdata [2];
  logic [1:0]    exp_drive [2];

  // Reference view of the port rules.
  function automatic bit picked(int p);
    return (ce0_n[p] == 1'b0) && (ce1[p] == 1'b1) && !sleep[p];
  endfunction

  function automatic logic [1:0] store_lanes(int p);
    if (picked(p) && rw[p] == 1'b0) return ~lane_n[p];
    return 2'b00;
  endfunction

  function automatic logic [1:0] show_lanes(int p);
    if (picked(p) && rw[p] == 1'b1 && oe_n[p] == 1'b0) return ~lane_n[p];
    return 2'b00;
  endfunction

  function automatic string mode_tag(int p);
    if (sleep[p])                  return "R7";
    if (!(ce0_n[p] == 1'b0 && ce1[p] == 1'b1)) return "R1";
    if (lane_n[p] == 2'b11)        return "R6";
    if (!rw[p])                    return "R3";
    if (oe_n[p])                   return "R5";
    return "R4";
  endfunction

  task automatic check(string tag, string what, int p,
                       logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port%0d %s actual %h expected %h", tag, p, what, act, exp);
    end
  endtask

  task automatic set_port(int p, logic c0n, logic c1, logic rwi, logic oen,
                          logic [1:0] ln, logic slp, logic [AW-1:0] ad,
                          logic [WW-1:0] wd);
    ce0_n[p] = c0n; ce1[p] = c1; rw[p] = rwi; oe_n[p] = oen;
    lane_n[p] = ln; sleep[p] = slp; addr[p] = ad; wdata[p] = wd;
  endtask

  task automatic set_idle(int p);
    set_port(p, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0);
  endtask

  task automatic rd(int p, logic [AW-1:0] ad);
    set_port(p, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, ad, '0);
  endtask

  task automatic wr(int p, logic [AW-1:0] ad, logic [1:0] ln, logic [WW-1:0] wd);
    set_port(p, 1'b0, 1'b1, 1'b0, 1'b0, ln, 1'b0, ad, wd);
  endtask

  // One clock: predict, update model (right then left so left wins), check.
  task automatic tick(string tag);
    string tg [2];
    for (int p = 0; p < 2; p++) begin
      logic [1:0] sl;
      tg[p] = (tag == "") ? mode_tag(p) : tag;
      sl = show_lanes(p);
      if (sl != 2'b00) exp_rdata[p] = model[addr[p]];
      exp_drive[p] = sl;
    end
    for (int p = 1; p >= 0; p--) begin
      logic [1:0] wl;
      wl = store_lanes(p);
      if (wl[0]) model[addr[p]][LW-1:0]  = wdata[p][LW-1:0];
      if (wl[1]) model[addr[p]][WW-1:LW] = wdata[p][WW-1:LW];
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      check(tg[p], "drive", p, WW'(drive[p]), WW'(exp_drive[p] & {2{~sleep[p]}}));
      check(tg[p], "rdata", p, rdata[p], exp_rdata[p]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the end of the run");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_0017);
    set_idle(0);
    set_idle(1);
    exp_rdata[0] = '0; exp_rdata[1] = '0;
    exp_drive[0] = '0; exp_drive[1] = '0;
    repeat (3) @(negedge clk);
    // R11: state while in reset
    for (int p = 0; p < 2; p++) begin
      check("R11", "drive", p, WW'(drive[p]), '0);
      check("R11", "rdata", p, rdata[p], '0);
    end
    rst_n = 1'b1;
    tick("R11");

    // Preload every word, both ports writing at once (R3, oe_n ignored).
    for (int i = 0; i < DEPTH/2; i++) begin
      wr(0, AW'(i), 2'b00, WW'(18'h01234 + i * 18'h00111));
      wr(1, AW'(i + DEPTH/2), 2'b00, WW'(18'h2a5a0 ^ (i * 18'h00307)));
      tick("R3");
    end

    // R8: same word read by both ports
    rd(0, 4'd2); rd(1, 4'd2); tick("R8");
    rd(0, 4'd9); rd(1, 4'd9); tick("R8");

    // R2: lower lane only, then upper lane only
    wr(0, 4'd6, 2'b10, 18'h3ffff); set_idle(1); tick("R2");
    rd(0, 4'd6); tick("R2");
    wr(1, 4'd6, 2'b01, 18'h00000); set_idle(0); tick("R2");
    rd(1, 4'd6); tick("R2");
    // R4: read with only upper lane driven
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 4'd10, '0); set_idle(1);
    tick("R4");

    // R10: same lane collision, then split lanes
    wr(0, 4'd3, 2'b00, 18'h15555); wr(1, 4'd3, 2'b00, 18'h0aaaa); tick("R10");
    rd(0, 4'd3); rd(1, 4'd3); tick("R10");
    wr(0, 4'd4, 2'b10, 18'h000f1); wr(1, 4'd4, 2'b01, 18'h3e000); tick("R10");
    rd(0, 4'd4); set_idle(1); tick("R10");

    // R9: read during the other port's write
    wr(0, 4'd5, 2'b00, 18'h2468a); rd(1, 4'd5); tick("R9");
    set_idle(0); rd(1, 4'd5); tick("R9");

    // R5: outputs held off
    set_port(0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 4'd1, '0); set_idle(1);
    tick("R5");

    // R6: no lane picked, write attempt then readback
    wr(0, 4'd7, 2'b11, 18'h3ffff); tick("R6");
    rd(0, 4'd7); tick("R6");

    // R1: each bad enable pair with write controls, then readback
    set_port(0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 4'd8, 18'h11111); tick("R1");
    set_port(0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 4'd8, 18'h22222); tick("R1");
    set_port(0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 4'd8, '0); tick("R1");
    rd(0, 4'd8); tick("R1");

    // R12: idle cycles keep the last word
    set_idle(0); tick("R12"); tick("R12");

    // R7: sleep releases drive in the same cycle and blocks a write
    rd(0, 4'd11); tick("R4");
    sleep[0] = 1'b1;
    #1;
    check("R7", "drive", 0, WW'(drive[0]), '0);
    wr(0, 4'd11, 2'b00, 18'h0f0f0); sleep[0] = 1'b1; tick("R7");
    rd(0, 4'd11); tick("R7");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < 2; p++) begin
        set_port(p, ($urandom % 6) == 0, ($urandom % 6) != 0, $urandom % 2,
                 ($urandom % 4) == 0, 2'($urandom), ($urandom % 9) == 0,
                 AW'($urandom), WW'($urandom));
      end
      tick("");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule